// File: doc/BRIEF.md
# Conversion Result FIFO Register

This block is a single 32-bit memory-mapped data register placed in front of a small FIFO that collects results from a converter. The converter pushes one result per cycle through a push port. Software reads the register through a bus read port that carries an address and per-byte lane enables. The upper half-word shows the oldest queued result. The lower half-word carries status: an invalid flag that tells whether the result shown is real, and a sticky overrun flag.

The byte lanes a read covers decide whether it has a side effect. A read that covers byte 2 or byte 3 takes in the upper half-word, so it consumes the head result. A read that covers only bytes 0 and 1 samples status and leaves the queue alone. Software can therefore poll the invalid flag with narrow reads as often as it likes without losing data, and then fetch each result with a word read. The overrun flag is cleared by writing 1 to it.

Top module: `conv_result_fifo_reg`

## Requirements
- R1: After a synchronous active-high reset the queue is empty, the overrun flag is 0 and `rd_data` is 0.
- R2: A read at `REG_ADDR` returns its word on `rd_data` in the cycle after `rd_en`. Bit 0 is the invalid flag: 1 when the queue is empty, 0 otherwise. Bit 1 is the overrun flag. Bits 16 upward hold the head result, right-aligned, `DATA_W` bits wide. All other bits are 0. Byte lanes not enabled read as 0. In any cycle without a read hit, `rd_data` is 0.
- R3: A read at `REG_ADDR` with lane enable bit 2 or bit 3 set removes exactly one entry. Entries leave in the order they were pushed.
- R4: A read at `REG_ADDR` whose lane enables cover only bits 0 and 1 (or no lanes) returns status and removes no entry.
- R5: A consuming read on an empty queue returns zero result bits and changes nothing.
- R6: The queue holds `DEPTH` entries (8 by default). A push into a full queue, with no pop in the same cycle, is discarded and sets the overrun flag, which stays set.
- R7: A write at `REG_ADDR` with lane enable bit 0 set and write-data bit 1 equal to 1 clears the overrun flag. A write with data bit 1 equal to 0, with lane bit 0 clear, or to another address leaves the flag unchanged. When a discarded push happens in the same cycle as a clear, the flag stays set.
- R8: A push in the same cycle as a consuming read of a non-empty queue, including a full one, is accepted and leaves the entry count unchanged. On an empty queue the push is accepted and the read returns invalid.
- R9: A read or write at any address other than `REG_ADDR` returns 0 and neither removes an entry nor changes the overrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Converter presents a result this cycle |
| push_data | input | DATA_W | Converter result |
| bus_rd_en | input | 1 | Bus read request |
| bus_wr_en | input | 1 | Bus write request |
| bus_addr | input | ADDR_W | Bus address |
| bus_lanes | input | 4 | Byte lane enables, bit n covers bits 8n+7..8n |
| bus_wr_data | input | 32 | Bus write data |
| rd_data | output | 32 | Registered read data |

## Verification
The bench builds the block with its defaults: `DEPTH` = 8, `DATA_W` = 12, `ADDR_W` = 4 and `REG_ADDR` = 0. With a queue this shallow, all 16 lane-enable patterns can be swept against an empty queue and against a filled one. Filling to full, overrunning and draining back to empty also take only a few dozen cycles. For the same reason, same-cycle push and pop can be applied to an empty, a partly filled and a full queue, and each result is compared with an arithmetic model of the queue and of the lane mask.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
  localparam int BUS_W       = 32;
  localparam int LANES       = BUS_W / 8;
  localparam int BIT_INVALID = 0;
  localparam int BIT_OVERRUN = 1;
  localparam int RESULT_LSB  = 16;

  // A read takes in the upper half-word when it enables lane 2 or lane 3.
  function automatic logic lanes_reach_upper(input logic [LANES-1:0] lanes);
    return lanes[2] | lanes[3];
  endfunction

  function automatic logic [BUS_W-1:0] lane_mask(input logic [LANES-1:0] lanes);
    logic [BUS_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{lanes[i]}};
    return m;
  endfunction
endpackage

// File: rtl/cfr_store.sv
module cfr_store #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 12,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  wptr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  rptr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wptr] <= wdata;
  end

  assign rdata = mem[rptr];
endmodule

// File: rtl/cfr_ctrl.sv
module cfr_ctrl #(
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic             pop_req,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             drop,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] count_q;

  assign empty   = (count_q == '0);
  assign full    = (count_q == CNT_W'(DEPTH));
  assign pop_ok  = pop_req && !empty;
  assign push_ok = push_req && (!full || pop_ok);
  assign drop    = push_req && !push_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_ok) wptr_q <= (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (pop_ok)  rptr_q <= (rptr_q == PTR_W'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      count_q <= count_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  assign wptr  = wptr_q;
  assign rptr  = rptr_q;
  assign count = count_q;

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_W'(DEPTH));

  assert_empty_pop_no_effect_R5: assert property (@(posedge clk) disable iff (rst)
    (pop_req && empty && !push_req) |=> (count_q == '0) && $stable(rptr_q));

  assert_push_pop_count_R8: assert property (@(posedge clk) disable iff (rst)
    (push_req && pop_req && !empty) |=> count_q == $past(count_q));
endmodule

// File: rtl/cfr_decode.sv
module cfr_decode
  import cfr_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0
) (
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lanes,
  input  logic [BUS_W-1:0]  wr_data,
  output logic              read_hit,
  output logic              pop_req,
  output logic              ovr_clear
);
  logic addr_hit;

  assign addr_hit  = (addr == ADDR_W'(REG_ADDR));
  assign read_hit  = rd_en && addr_hit;
  assign pop_req   = read_hit && lanes_reach_upper(lanes);
  assign ovr_clear = wr_en && addr_hit && lanes[0] && wr_data[BIT_OVERRUN];
endmodule

// File: rtl/conv_result_fifo_reg.sv
module conv_result_fifo_reg
  import cfr_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int DATA_W   = 12,
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              bus_rd_en,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_lanes,
  input  logic [31:0]       bus_wr_data,
  output logic [31:0]       rd_data
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              read_hit, pop_req, ovr_clear;
  logic              push_ok, pop_ok, drop, empty, full;
  logic [PTR_W-1:0]  wptr, rptr;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] head;
  logic              overrun_q;
  logic [BUS_W-1:0]  rd_q, word;

  cfr_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_decode (
    .rd_en(bus_rd_en), .wr_en(bus_wr_en), .addr(bus_addr), .lanes(bus_lanes),
    .wr_data(bus_wr_data), .read_hit(read_hit), .pop_req(pop_req), .ovr_clear(ovr_clear)
  );

  cfr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .push_req(push_valid), .pop_req(pop_req),
    .push_ok(push_ok), .pop_ok(pop_ok), .drop(drop), .wptr(wptr), .rptr(rptr),
    .count(count), .empty(empty), .full(full)
  );

  cfr_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .we(push_ok), .wptr(wptr), .wdata(push_data), .rptr(rptr), .rdata(head)
  );

  always_comb begin
    word = '0;
    word[BIT_INVALID] = empty;
    word[BIT_OVERRUN] = overrun_q;
    if (!empty) word[RESULT_LSB +: DATA_W] = head;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      overrun_q <= 1'b0;
      rd_q      <= '0;
    end else begin
      if (drop)           overrun_q <= 1'b1;
      else if (ovr_clear) overrun_q <= 1'b0;
      rd_q <= read_hit ? (word & lane_mask(bus_lanes)) : '0;
    end
  end

  assign rd_data = rd_q;

  assert_status_read_keeps_fifo_R4: assert property (@(posedge clk) disable iff (rst)
    (read_hit && !bus_lanes[2] && !bus_lanes[3] && !push_valid) |=> count == $past(count));

  assert_invalid_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (read_hit && bus_lanes[0]) |=> rd_data[BIT_INVALID] == $past(count == '0));

  assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (push_valid && full && !pop_ok) |=> overrun_q);

  assert_miss_no_pop_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && !read_hit && !push_valid) |=> (count == $past(count)) && (rd_data == '0));
endmodule

// File: tb/tb_conv_result_fifo_reg.sv
module tb_conv_result_fifo_reg;
  localparam int DEPTH = 8;
  localparam int DW    = 12;

  logic        clk = 0;
  logic        rst;
  logic        push_valid;
  logic [DW-1:0] push_data;
  logic        bus_rd_en, bus_wr_en;
  logic [3:0]  bus_addr;
  logic [3:0]  bus_lanes;
  logic [31:0] bus_wr_data;
  logic [31:0] rd_data;

  int errors = 0, checks = 0;
  int q[$];
  bit ovr = 0;
  int vseed = 1;
  bit done = 0;

  always #5 clk = ~clk;

  conv_result_fifo_reg dut (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
    .bus_rd_en(bus_rd_en), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_lanes(bus_lanes), .bus_wr_data(bus_wr_data), .rd_data(rd_data)
  );

  function automatic logic [31:0] mask_of(input logic [3:0] l);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{l[i]}};
    return m;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus/converter cycle, entered and left at a falling edge.
  task automatic step(input string tag, input bit psh, input int pval, input bit rd,
                      input bit wr, input logic [3:0] addr, input logic [3:0] lanes,
                      input logic [31:0] wdata);
    logic [31:0] exp;
    bit hit, pop_ok, push_ok, drop;
    hit = (addr == 4'h0);
    exp = 0;
    if (rd && hit) begin
      exp[0] = (q.size() == 0);
      exp[1] = ovr;
      if (q.size() > 0) exp[16 +: DW] = q[0][DW-1:0];
      exp = exp & mask_of(lanes);
    end
    pop_ok  = rd && hit && (lanes[2] || lanes[3]) && q.size() > 0;
    push_ok = psh && (q.size() < DEPTH || pop_ok);
    drop    = psh && !push_ok;
    push_valid = psh; push_data = pval[DW-1:0];
    bus_rd_en = rd; bus_wr_en = wr; bus_addr = addr; bus_lanes = lanes; bus_wr_data = wdata;
    @(negedge clk);
    push_valid = 0; bus_rd_en = 0; bus_wr_en = 0;
    if (pop_ok) void'(q.pop_front());
    if (push_ok) q.push_back(pval & ((1 << DW) - 1));
    if (drop) ovr = 1;
    else if (wr && hit && lanes[0] && wdata[1]) ovr = 0;
    if (rd) check(tag, rd_data, exp);
  endtask

  task automatic push(input int v);
    step("push", 1, v, 0, 0, 4'h0, 4'h0, 0);
  endtask

  function automatic int nextv();
    vseed = (vseed * 37 + 11) % 4096;
    return vseed;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    push_valid = 0; push_data = 0; bus_rd_en = 0; bus_wr_en = 0;
    bus_addr = 0; bus_lanes = 0; bus_wr_data = 0;
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    check("R1 rd_data after reset", rd_data, 32'h0);
    step("R1 R2 invalid after reset", 0, 0, 1, 0, 4'h0, 4'h1, 0);

    // R4 R5: all lane patterns on an empty queue
    for (int l = 0; l < 16; l++) step("R4 R5 empty lane sweep", 0, 0, 1, 0, 4'h0, 4'(l), 0);

    // R2 R3 R4: lane sweep on a non-empty queue, twice over
    for (int r = 0; r < 2; r++)
      for (int l = 0; l < 16; l++) begin
        while (q.size() < 3) push(nextv());
        step("R2 R3 R4 lane sweep", 0, 0, 1, 0, 4'h0, 4'(l), 0);
      end
    while (q.size() > 0) step("R3 drain order", 0, 0, 1, 0, 4'h0, 4'hF, 0);

    // R6: fill, overrun, drain
    for (int i = 0; i < DEPTH; i++) push(100 + i);
    push(999);
    step("R6 overrun flag set", 0, 0, 1, 0, 4'h0, 4'h1, 0);
    check("R6 queue stays at depth", q.size(), DEPTH);
    // R9: miss address read returns zero and does not pop
    step("R9 read at other address", 0, 0, 1, 0, 4'h4, 4'hF, 0);
    step("R9 write at other address", 0, 0, 0, 1, 4'h4, 4'h1, 32'h2);
    // R7: non-clearing writes
    step("R7 write zero", 0, 0, 0, 1, 4'h0, 4'h1, 32'h0);
    step("R7 write without lane0", 0, 0, 0, 1, 4'h0, 4'hE, 32'h2);
    step("R7 R9 flag still set", 0, 0, 1, 0, 4'h0, 4'h3, 0);
    // R7: clear racing a discarded push keeps the flag set
    step("R7 set wins", 1, 555, 0, 1, 4'h0, 4'h1, 32'h2);
    step("R7 flag after race", 0, 0, 1, 0, 4'h0, 4'h1, 0);
    while (q.size() > 0) step("R6 drain full queue", 0, 0, 1, 0, 4'h0, 4'hF, 0);
    step("R6 overrun sticky on empty", 0, 0, 1, 0, 4'h0, 4'hF, 0);
    step("R7 clear", 0, 0, 0, 1, 4'h0, 4'h1, 32'h2);
    step("R7 flag cleared", 0, 0, 1, 0, 4'h0, 4'h1, 0);

    // R8: same-cycle push and pop
    push(11); push(22);
    step("R8 push+pop nonempty", 1, 33, 1, 0, 4'h0, 4'hC, 0);
    check("R8 count unchanged", q.size(), 2);
    step("R8 order after", 0, 0, 1, 0, 4'h0, 4'hF, 0);
    step("R8 order after", 0, 0, 1, 0, 4'h0, 4'hF, 0);
    step("R8 push+pop empty", 1, 44, 1, 0, 4'h0, 4'hF, 0);
    step("R8 pushed on empty", 0, 0, 1, 0, 4'h0, 4'hF, 0);
    for (int i = 0; i < DEPTH; i++) push(200 + i);
    step("R8 push+pop full", 1, 300, 1, 0, 4'h0, 4'h4, 0);
    step("R8 R6 no overrun on full push+pop", 0, 0, 1, 0, 4'h0, 4'h1, 0);
    while (q.size() > 0) step("R8 drain after full", 0, 0, 1, 0, 4'h0, 4'hF, 0);
    step("R5 empty at end", 0, 0, 1, 0, 4'h0, 4'hF, 0);

    // R1: reset clears queue and flag
    push(7); push(1); push(2); push(3); push(4); push(5); push(6); push(8); push(9);
    rst = 1; @(negedge clk); rst = 0;
    q.delete(); ovr = 0;
    check("R1 rd_data after second reset", rd_data, 32'h0);
    step("R1 status after second reset", 0, 0, 1, 0, 4'h0, 4'hF, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule